// File: doc/BRIEF.md
# Burst Address and Byte-Lane Generator

This block expands one memory-mapped burst command into a stream of beats. A command carries a start byte address, a burst kind, a beat count and a per-beat transfer size. For every beat the block presents the byte address of that beat, a byte-lane strobe for a data bus that may be wider than the transfer, and a flag on the final beat. A data path or memory-side engine consumes the beats and can stall them at will.

Three burst kinds are handled. A fixed burst repeats one address, as when a FIFO window is filled or drained. An incrementing burst steps by the transfer size, and the first beat may be unaligned. A wrapping burst steps the same way inside an aligned window of beats times size bytes and folds back to the window base, as for a cache-line fill that starts at the critical word. Commands the block cannot serve are refused with a one-cycle error pulse and produce no beats.

Both the command side and the beat side are valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no burst is active. A beat transfers on an edge where `beat_valid` and `beat_ready` are both high. While `beat_valid` is high and `beat_ready` is low, every beat output holds its value.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `beat_valid` and `cmd_err` are 0.
- R2: A legal command accepted on an edge makes `beat_valid` high after that edge, with the first beat at the start address. `cmd_ready` stays low until the edge where the final beat is taken, and is high again after that edge.
- R3: For `cmd_kind` 0 (fixed), every beat carries the start address and the same strobe.
- R4: For `cmd_kind` 1 (incrementing), beat n (n ≥ 1) carries the start address rounded down to a multiple of the size, plus n times the size in bytes.
- R5: For `cmd_kind` 2 (wrapping), the window is beats × size bytes and is aligned to its own length. Beat n carries window base + ((start + n × size) mod window).
- R6: `beat_strb` bit i is set when i is at least the beat address modulo the bus byte width, and i is below the end of the size-aligned chunk that holds that address. Narrow beats therefore move across lanes in modes 1 and 2, and an unaligned first beat begins at its start byte.
- R7: `beat_last` is 1 on beat number `cmd_len` (counting from 0) and 0 on every other beat. The burst has `cmd_len`+1 beats, up to 16.
- R8: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr`, `beat_strb` and `beat_last` keep their values and `beat_valid` stays 1.
- R9: A command is refused when 2^`cmd_size` exceeds the bus byte width, when `cmd_kind` is 3, or when it is a wrap whose beat count is not 2, 4, 8 or 16 or whose address is not a multiple of the size. A refused command pulses `cmd_err` for exactly the one cycle after acceptance, produces no beat, and leaves `cmd_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| cmd_len | input | 4 | Beat count minus one |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_err | output | 1 | One-cycle pulse: last accepted command refused |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | ADDR_W | Byte address of the beat |
| beat_strb | output | DATA_W/8 | Active byte lanes of the beat |
| beat_last | output | 1 | Final beat of the burst |

## Verification
Every result is due one edge after the handshake that causes it. The first beat and `cmd_err` follow the command edge, each later beat follows the edge that took the previous beat, and `cmd_ready` returns after the edge that took the final beat. The bench drives inputs and samples outputs on the falling edge. It reads each beat in the half cycle before the edge that consumes it, and reads the error pulse and idle state in the half cycle that follows the relevant edge. Stall checks sample the same beat on two falling edges around a rising edge with `beat_ready` low, and expect no change.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'd0,
    BK_INCR  = 2'd1,
    BK_WRAP  = 2'd2,
    BK_RSVD  = 2'd3
  } burst_kind_e;
endpackage

// File: rtl/burst_cmd_check.sv
module burst_cmd_check
  import burst_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 4,
  parameter int MAX_SIZE = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  burst_kind_e       kind,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        size,
  output logic              legal
);
  logic [ADDR_W-1:0] size_mask;
  logic              size_ok;
  logic              wrap_len_ok;
  logic              wrap_align_ok;

  always_comb begin
    size_mask     = (ADDR_W'(1) << size) - ADDR_W'(1);
    size_ok       = (32'(size) <= MAX_SIZE);
    // beat count must be a power of two of at least two
    wrap_len_ok   = (len != '0) && ((len & (len + LEN_W'(1))) == '0);
    wrap_align_ok = ((addr & size_mask) == '0);
    unique case (kind)
      BK_FIXED, BK_INCR: legal = size_ok;
      BK_WRAP:           legal = size_ok && wrap_len_ok && wrap_align_ok;
      default:           legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  burst_kind_e       kind,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        size,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] step_mask;
  logic [ADDR_W-1:0] win_mask;

  always_comb begin
    step      = ADDR_W'(1) << size;
    step_mask = step - ADDR_W'(1);
    win_mask  = (step * (ADDR_W'(len) + ADDR_W'(1))) - ADDR_W'(1);
    unique case (kind)
      BK_FIXED: next_addr = cur_addr;
      BK_WRAP:  next_addr = (cur_addr & ~win_mask) | ((cur_addr + step) & win_mask);
      default:  next_addr = (cur_addr & ~step_mask) + step;
    endcase
  end
endmodule

// File: rtl/burst_lane_mask.sv
module burst_lane_mask #(
  parameter int STRB_W = 4,
  localparam int LANE_W = $clog2(STRB_W)
) (
  input  logic [LANE_W-1:0] lane_addr,
  input  logic [2:0]        size,
  output logic [STRB_W-1:0] strb
);
  logic [LANE_W:0] chunk;
  logic [LANE_W:0] first;
  logic [LANE_W:0] stop;

  always_comb begin
    chunk = (LANE_W+1)'(1) << size;
    first = {1'b0, lane_addr};
    stop  = (first & ~(chunk - (LANE_W+1)'(1))) + chunk;
  end

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    assign strb[i] = ((LANE_W+1)'(i) >= first) && ((LANE_W+1)'(i) < stop);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 16,
  localparam int STRB_W   = DATA_W / 8,
  localparam int LANE_W   = $clog2(STRB_W),
  localparam int LEN_W    = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_kind,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [2:0]        cmd_size,
  output logic              cmd_err,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [STRB_W-1:0] beat_strb,
  output logic              beat_last
);
  logic              busy_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q;
  burst_kind_e       kind_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [2:0]        size_q;
  logic              cmd_legal;
  logic [ADDR_W-1:0] addr_nxt;
  logic              cmd_take;
  logic              beat_take;

  assign cmd_ready  = !busy_q;
  assign cmd_take   = cmd_valid && cmd_ready;
  assign beat_valid = busy_q;
  assign beat_take  = beat_valid && beat_ready;
  assign beat_addr  = addr_q;
  assign beat_last  = (cnt_q == len_q);
  assign cmd_err    = err_q;

  burst_cmd_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_SIZE(LANE_W)) u_check (
    .addr  (cmd_addr),
    .kind  (burst_kind_e'(cmd_kind)),
    .len   (cmd_len),
    .size  (cmd_size),
    .legal (cmd_legal)
  );

  burst_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
    .cur_addr  (addr_q),
    .kind      (kind_q),
    .len       (len_q),
    .size      (size_q),
    .next_addr (addr_nxt)
  );

  burst_lane_mask #(.STRB_W(STRB_W)) u_lanes (
    .lane_addr (addr_q[LANE_W-1:0]),
    .size      (size_q),
    .strb      (beat_strb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      kind_q <= BK_FIXED;
      len_q  <= '0;
      cnt_q  <= '0;
      size_q <= '0;
    end else begin
      err_q <= cmd_take && !cmd_legal;
      if (cmd_take && cmd_legal) begin
        busy_q <= 1'b1;
        addr_q <= cmd_addr;
        kind_q <= burst_kind_e'(cmd_kind);
        len_q  <= cmd_len;
        size_q <= cmd_size;
        cnt_q  <= '0;
      end else if (beat_take) begin
        if (beat_last) begin
          busy_q <= 1'b0;
        end else begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q + LEN_W'(1);
        end
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
      && $stable(beat_strb) && $stable(beat_last));

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_legal |=> beat_valid && !cmd_ready
      && beat_addr == $past(cmd_addr));

  // R2
  last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> cmd_ready && !beat_valid);

  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_legal |=> cmd_err && !beat_valid && cmd_ready);

  // R3
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(beat_valid && beat_ready && !beat_last) && kind_q == BK_FIXED
      |-> beat_addr == $past(beat_addr) && beat_strb == $past(beat_strb));

  // R6
  strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_strb != '0 && $countones(beat_strb) <= (1 << size_q));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NB     = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [1:0]        cmd_kind = '0;
  logic [3:0]        cmd_len = '0;
  logic [2:0]        cmd_size = '0;
  logic              cmd_err;
  logic              beat_valid;
  logic              beat_ready = 1'b0;
  logic [ADDR_W-1:0] beat_addr;
  logic [NB-1:0]     beat_strb;
  logic              beat_last;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_kind, .cmd_len,
    .cmd_size, .cmd_err, .beat_valid, .beat_ready, .beat_addr, .beat_strb,
    .beat_last
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input int kind,
                                           input int len, input int size, input int n);
    int sz = 1 << size;
    int win = sz * (len + 1);
    logic [31:0] base;
    if (kind == 0 || n == 0) return a;
    if (kind == 1) return (a / sz) * sz + n * sz;
    base = (a / win) * win;
    return base + ((a + n * sz) % win);
  endfunction

  function automatic logic [NB-1:0] exp_strb(input logic [31:0] a, input int size);
    int sz = 1 << size;
    int lo = a % NB;
    int hi = ((a % NB) / sz) * sz + sz;
    logic [NB-1:0] s = '0;
    for (int i = 0; i < NB; i++) s[i] = (i >= lo) && (i < hi);
    return s;
  endfunction

  task automatic send(input logic [31:0] a, input int kind, input int len, input int size);
    cmd_addr  = a;
    cmd_kind  = 2'(kind);
    cmd_len   = 4'(len);
    cmd_size  = 3'(size);
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // runs one legal burst; stall_at >= 0 holds beat_ready low for one cycle on that beat
  task automatic run_burst(input string req, input logic [31:0] a, input int kind,
                           input int len, input int size, input int stall_at);
    @(negedge clk);
    send(a, kind, len, size);
    check("R2", "busy after accept", {63'd0, cmd_ready}, 64'd0);
    for (int n = 0; n <= len; n++) begin
      logic [31:0] ea = exp_addr(a, kind, len, size, n);
      logic [NB-1:0] es = exp_strb(ea, size);
      if (n == stall_at) begin
        beat_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8", "valid held in stall", {63'd0, beat_valid}, 64'd1);
        check("R8", "addr held in stall", 64'(beat_addr), 64'(ea));
        check("R8", "strb held in stall", 64'(beat_strb), 64'(es));
      end
      check("R2", "beat valid", {63'd0, beat_valid}, 64'd1);
      check(req, $sformatf("addr beat %0d", n), 64'(beat_addr), 64'(ea));
      check("R6", $sformatf("strb beat %0d", n), 64'(beat_strb), 64'(es));
      check("R7", $sformatf("last beat %0d", n), {63'd0, beat_last}, 64'(n == len));
      beat_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      beat_ready = 1'b0;
    end
    check("R2", "idle after last", {63'd0, cmd_ready}, 64'd1);
    check("R2", "no beat after last", {63'd0, beat_valid}, 64'd0);
  endtask

  task automatic run_reject(input string what, input logic [31:0] a, input int kind,
                            input int len, input int size);
    @(negedge clk);
    send(a, kind, len, size);
    check("R9", {what, " err pulse"}, {63'd0, cmd_err}, 64'd1);
    check("R9", {what, " no beat"}, {63'd0, beat_valid}, 64'd0);
    check("R9", {what, " ready kept"}, {63'd0, cmd_ready}, 64'd1);
    @(negedge clk);
    check("R9", {what, " err one cycle"}, {63'd0, cmd_err}, 64'd0);
    check("R9", {what, " still no beat"}, {63'd0, beat_valid}, 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cmd_ready", {63'd0, cmd_ready}, 64'd1);
    check("R1", "beat_valid", {63'd0, beat_valid}, 64'd0);
    check("R1", "cmd_err", {63'd0, cmd_err}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_burst("R4", 32'h100, 1, 3, 2, -1);   // aligned word incr
    run_burst("R4", 32'h103, 1, 2, 2, -1);   // unaligned first beat
    run_burst("R4", 32'h011, 1, 5, 0, -1);   // narrow byte incr crossing lanes
    run_burst("R4", 32'h202, 1, 3, 1, 1);    // halfword incr with stall
    run_burst("R3", 32'h022, 0, 3, 1, -1);   // fixed narrow
    run_burst("R3", 32'h301, 0, 0, 0, 0);    // single beat fixed with stall
    run_burst("R5", 32'h038, 2, 3, 2, -1);   // word wrap of 4
    run_burst("R5", 32'h045, 2, 7, 0, 2);    // byte wrap of 8 with stall
    run_burst("R5", 32'h0F0, 2, 15, 2, -1);  // 16-beat wrap
    run_burst("R7", 32'h400, 1, 15, 2, -1);  // maximum length incr
    run_reject("oversize", 32'h0, 1, 1, 3);
    run_reject("reserved kind", 32'h0, 3, 1, 2);
    run_reject("wrap length 3", 32'h40, 2, 2, 2);
    run_reject("wrap misaligned", 32'h39, 2, 3, 2);
    run_reject("wrap single beat", 32'h40, 2, 0, 0);
    run_burst("R4", 32'h500, 1, 1, 2, -1);   // normal service after rejects
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule